// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block sits between the internal clock sources of a clock generator and its output buffers. It passes three families of generated clocks: a CPU group of differential pairs, an SRC group of differential pairs plus one LCD differential pair (both from the SRC source clock), and a PCI group of single-ended clocks plus one free-running-capable PCIF clock. Two active-low stop pins, one for the CPU group and one for the PCI/SRC side, together with a software run bit, park the outputs that are marked stoppable. Outputs not marked stoppable keep running.

Stop requests are treated as asynchronous. Each is resynchronised by two flops clocked on the falling edge of the source clock, that is, on the rising edge of the internal complement clock. Each output then changes its gate enable only while the output already sits at its park level. A differential pair parks with its true leg high and its complement leg low. A single-ended clock parks low. As a result, neither stopping nor restarting can shorten a clock phase. Each output also has an enable that forces it (both legs for a pair) low, whatever the stop logic is doing.

Top module: `clkstop_gate_top`

## Requirements
- R1: With `cpu_stop_n` low and `cpu_stop_en[i]` = 1, CPU pair i parks with `cpu_p[i]` = 1 and `cpu_n[i]` = 0 no later than six `cpu_clk` periods after the assertion.
- R2: A CPU pair whose `cpu_stop_en` bit is 0 keeps toggling, with true and complement legs opposite, while `cpu_stop_n` is low.
- R3: After `cpu_stop_n` returns high, every parked CPU pair toggles again within four `cpu_clk` periods.
- R4: No gated output ever shows a high or low phase shorter than half the period of its source clock, across stop, restart and stop-enable changes.
- R5: With `pci_stop_n` low, each PCI output is driven low. Each SRC pair parks true-high/complement-low when `src_stop_en` = 1. The LCD pair parks the same way when `lcd_stop_en` = 1. The PCIF output is low when `pcif_stop_en` = 1. All of this takes effect within six periods of the relevant source clock.
- R6: During a PCI stop, the SRC pairs, the LCD pair and the PCIF output keep running when their respective stop-enable input is 0.
- R7: After `pci_stop_n` returns high, every output stopped by it toggles again within four periods of its own source clock.
- R8: `sw_run` = 0 stops the same outputs as `pci_stop_n` = 0, and `sw_run` = 1 (with `pci_stop_n` high) resumes them.
- R9: An output whose enable input is 0 is held low, and for a pair both legs are held low, whether or not a stop is active.
- R10: A CPU stop leaves the SRC, LCD, PCI and PCIF outputs running, and a PCI stop leaves the CPU pairs running.
- R11: After reset is released with no stop requested, every enabled output toggles, and each CPU pair has opposite levels on its two legs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Internal CPU source clock |
| src_clk | input | 1 | Internal SRC/LCD source clock |
| pci_clk | input | 1 | Internal PCI source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low CPU group stop request |
| pci_stop_n | input | 1 | Active-low PCI/SRC stop request |
| sw_run | input | 1 | Software run bit, 0 acts as a PCI/SRC stop |
| cpu_stop_en | input | N_CPU | Per-pair CPU stoppable mask |
| src_stop_en | input | 1 | SRC pairs stoppable by PCI stop |
| lcd_stop_en | input | 1 | LCD pair stoppable by PCI stop |
| pcif_stop_en | input | 1 | PCIF output stoppable by PCI stop |
| cpu_oe | input | N_CPU | CPU pair enables |
| src_oe | input | N_SRC | SRC pair enables |
| lcd_oe | input | 1 | LCD pair enable |
| pci_oe | input | N_PCI | PCI output enables |
| pcif_oe | input | 1 | PCIF output enable |
| cpu_p | output | N_CPU | CPU true legs |
| cpu_n | output | N_CPU | CPU complement legs |
| src_p | output | N_SRC | SRC true legs |
| src_n | output | N_SRC | SRC complement legs |
| lcd_p | output | 1 | LCD true leg |
| lcd_n | output | 1 | LCD complement leg |
| pci_out | output | N_PCI | PCI single-ended clocks |
| pcif_out | output | 1 | PCIF single-ended clock |

## Verification
A stuck or wrongly reset synchroniser stage shows at the ports as a pair that never parks, or that parks late, within a few source periods of a stop edge. The bench observes this by sampling the parked level after a fixed wait and counting edges over a later window. A gate enable that updates in the wrong clock phase does not change the steady levels. It does show as one clipped phase at the moment of stop or restart, so the bench times every edge of every output and flags any phase shorter than half a source period. A crossed stop mask or a mis-routed group request appears as a free-running output that parks, or the reverse, in the same window.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  // flops in each stop-request resynchroniser
  localparam int SYNC_STAGES = 2;

  // an output keeps running unless a stop is pending and it is marked stoppable
  function automatic logic keep_running(input logic stop_req, input logic stoppable);
    return !(stop_req && stoppable);
  endfunction

  // the PCI/SRC side stops on the pin or on the software bit
  function automatic logic group_stop_raw(input logic pin_n, input logic run_bit);
    return !pin_n || !run_bit;
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int STAGES = clkstop_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  // sampled on the complement clock: falling edge of the source clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/clkstop_gate_diff.sv
module clkstop_gate_diff (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic oe,
  output logic out_p,
  output logic out_n
);
  logic en;

  // enable moves only while clk is high: true leg is already high, complement low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b1;
    else        en <= run;
  end

  assign out_p = oe & (clk | ~en);
  assign out_n = oe & ~clk & en;
endmodule

// File: rtl/clkstop_gate_se.sv
module clkstop_gate_se (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic oe,
  output logic out
);
  logic en;

  // enable moves only while clk is low, the park level of a single-ended clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b1;
    else        en <= run;
  end

  assign out = oe & clk & en;
endmodule

// File: rtl/clkstop_gate_top.sv
module clkstop_gate_top #(
  parameter int N_CPU = 2,
  parameter int N_SRC = 4,
  parameter int N_PCI = 3
) (
  input  logic             cpu_clk,
  input  logic             src_clk,
  input  logic             pci_clk,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             sw_run,
  input  logic [N_CPU-1:0] cpu_stop_en,
  input  logic             src_stop_en,
  input  logic             lcd_stop_en,
  input  logic             pcif_stop_en,
  input  logic [N_CPU-1:0] cpu_oe,
  input  logic [N_SRC-1:0] src_oe,
  input  logic             lcd_oe,
  input  logic [N_PCI-1:0] pci_oe,
  input  logic             pcif_oe,
  output logic [N_CPU-1:0] cpu_p,
  output logic [N_CPU-1:0] cpu_n,
  output logic [N_SRC-1:0] src_p,
  output logic [N_SRC-1:0] src_n,
  output logic             lcd_p,
  output logic             lcd_n,
  output logic [N_PCI-1:0] pci_out,
  output logic             pcif_out
);
  import clkstop_pkg::*;

  // named internal events, observed by the bound checker
  logic             cpu_stop_raw;
  logic             pci_stop_raw;
  logic             cpu_stop_q;
  logic             src_stop_q;
  logic             pci_stop_q;
  logic [N_CPU-1:0] cpu_run;
  logic [N_SRC-1:0] src_run;
  logic [N_PCI-1:0] pci_run;
  logic             lcd_run;
  logic             pcif_run;

  assign cpu_stop_raw = !cpu_stop_n;
  assign pci_stop_raw = group_stop_raw(pci_stop_n, sw_run);

  clkstop_sync u_sync_cpu (.clk(cpu_clk), .rst_n(rst_n), .d(cpu_stop_raw), .q(cpu_stop_q));
  clkstop_sync u_sync_src (.clk(src_clk), .rst_n(rst_n), .d(pci_stop_raw), .q(src_stop_q));
  clkstop_sync u_sync_pci (.clk(pci_clk), .rst_n(rst_n), .d(pci_stop_raw), .q(pci_stop_q));

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    assign cpu_run[i] = keep_running(cpu_stop_q, cpu_stop_en[i]);
    clkstop_gate_diff u_gate (
      .clk(cpu_clk), .rst_n(rst_n), .run(cpu_run[i]), .oe(cpu_oe[i]),
      .out_p(cpu_p[i]), .out_n(cpu_n[i])
    );
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign src_run[i] = keep_running(src_stop_q, src_stop_en);
    clkstop_gate_diff u_gate (
      .clk(src_clk), .rst_n(rst_n), .run(src_run[i]), .oe(src_oe[i]),
      .out_p(src_p[i]), .out_n(src_n[i])
    );
  end

  assign lcd_run = keep_running(src_stop_q, lcd_stop_en);
  clkstop_gate_diff u_gate_lcd (
    .clk(src_clk), .rst_n(rst_n), .run(lcd_run), .oe(lcd_oe),
    .out_p(lcd_p), .out_n(lcd_n)
  );

  // PCI single-ended outputs are always stoppable
  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    assign pci_run[i] = keep_running(pci_stop_q, 1'b1);
    clkstop_gate_se u_gate (
      .clk(pci_clk), .rst_n(rst_n), .run(pci_run[i]), .oe(pci_oe[i]), .out(pci_out[i])
    );
  end

  assign pcif_run = keep_running(pci_stop_q, pcif_stop_en);
  clkstop_gate_se u_gate_pcif (
    .clk(pci_clk), .rst_n(rst_n), .run(pcif_run), .oe(pcif_oe), .out(pcif_out)
  );
endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk #(
  parameter int N_CPU = 2,
  parameter int N_SRC = 4,
  parameter int N_PCI = 3
) (
  input logic             cpu_clk,
  input logic             src_clk,
  input logic             pci_clk,
  input logic             rst_n,
  input logic             sw_run,
  input logic [N_CPU-1:0] cpu_stop_en,
  input logic             src_stop_en,
  input logic [N_CPU-1:0] cpu_oe,
  input logic [N_SRC-1:0] src_oe,
  input logic [N_PCI-1:0] pci_oe,
  input logic [N_CPU-1:0] cpu_p,
  input logic [N_CPU-1:0] cpu_n,
  input logic [N_SRC-1:0] src_p,
  input logic [N_SRC-1:0] src_n,
  input logic [N_PCI-1:0] pci_out,
  input logic             cpu_stop_q,
  input logic             src_stop_q,
  input logic             pci_stop_q
);
  // At a rising source edge the sampled clock is low, so a pair reads true=0/comp=1
  // when running and true=1/comp=0 when parked.
  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_chk
    p_cpu_park_r1: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (cpu_stop_q && cpu_stop_en[i]) |=> (!cpu_oe[i] || (cpu_p[i] && !cpu_n[i])));

    p_cpu_free_r2: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (!cpu_stop_en[i] && $past(!cpu_stop_en[i]) && cpu_oe[i]) |-> (!cpu_p[i] && cpu_n[i]));

    p_cpu_resume_r3: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      $fell(cpu_stop_q) |=> (!cpu_oe[i] || (!cpu_p[i] && cpu_n[i])));
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src_chk
    p_src_park_r5: assert property (@(posedge src_clk) disable iff (!rst_n)
      (src_stop_q && src_stop_en) |=> (!src_oe[i] || (src_p[i] && !src_n[i])));
  end

  // at a falling PCI edge the sampled clock is high, so a running output reads 1
  for (genvar i = 0; i < N_PCI; i++) begin : g_pci_chk
    p_pci_park_r5: assert property (@(negedge pci_clk) disable iff (!rst_n)
      pci_stop_q |=> (!pci_oe[i] || !pci_out[i]));
  end

  p_sw_stop_r8: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (!sw_run && $past(!sw_run) && $past(!sw_run, 2) && $past(rst_n, 2)) |-> pci_stop_q);
endmodule

bind clkstop_gate_top clkstop_gate_chk #(
  .N_CPU(N_CPU), .N_SRC(N_SRC), .N_PCI(N_PCI)
) u_chk (
  .cpu_clk(cpu_clk), .src_clk(src_clk), .pci_clk(pci_clk), .rst_n(rst_n),
  .sw_run(sw_run), .cpu_stop_en(cpu_stop_en), .src_stop_en(src_stop_en),
  .cpu_oe(cpu_oe), .src_oe(src_oe), .pci_oe(pci_oe),
  .cpu_p(cpu_p), .cpu_n(cpu_n), .src_p(src_p), .src_n(src_n), .pci_out(pci_out),
  .cpu_stop_q(cpu_stop_q), .src_stop_q(src_stop_q), .pci_stop_q(pci_stop_q)
);

// File: tb/clkstop_gate_top_tb_top.sv
module clkstop_gate_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SRC_PERIOD = 2 * CLK_PERIOD;
  localparam int PCI_PERIOD = 6 * CLK_PERIOD;
  localparam int NC = 2;
  localparam int NS = 4;
  localparam int NP = 3;
  localparam int W = 2*NC + 2*NS + 2 + NP + 1;
  localparam int I_CPUP = 0;
  localparam int I_CPUN = NC;
  localparam int I_SRCP = 2*NC;
  localparam int I_SRCN = 2*NC + NS;
  localparam int I_LCDP = 2*NC + 2*NS;
  localparam int I_LCDN = I_LCDP + 1;
  localparam int I_PCI  = I_LCDP + 2;
  localparam int I_PCIF = I_PCI + NP;

  logic cpu_clk = 1'b0, src_clk = 1'b0, pci_clk = 1'b0;
  logic rst_n, cpu_stop_n, pci_stop_n, sw_run;
  logic [NC-1:0] cpu_stop_en, cpu_oe;
  logic src_stop_en, lcd_stop_en, pcif_stop_en, lcd_oe, pcif_oe;
  logic [NS-1:0] src_oe;
  logic [NP-1:0] pci_oe;
  logic [NC-1:0] cpu_p, cpu_n;
  logic [NS-1:0] src_p, src_n;
  logic lcd_p, lcd_n, pcif_out;
  logic [NP-1:0] pci_out;

  always #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;
  always #(SRC_PERIOD/2) src_clk = ~src_clk;
  always #(PCI_PERIOD/2) pci_clk = ~pci_clk;

  clkstop_gate_top #(.N_CPU(NC), .N_SRC(NS), .N_PCI(NP)) dut_i (
    .cpu_clk(cpu_clk), .src_clk(src_clk), .pci_clk(pci_clk), .rst_n(rst_n),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .sw_run(sw_run),
    .cpu_stop_en(cpu_stop_en), .src_stop_en(src_stop_en), .lcd_stop_en(lcd_stop_en),
    .pcif_stop_en(pcif_stop_en), .cpu_oe(cpu_oe), .src_oe(src_oe), .lcd_oe(lcd_oe),
    .pci_oe(pci_oe), .pcif_oe(pcif_oe), .cpu_p(cpu_p), .cpu_n(cpu_n),
    .src_p(src_p), .src_n(src_n), .lcd_p(lcd_p), .lcd_n(lcd_n),
    .pci_out(pci_out), .pcif_out(pcif_out)
  );

  wire [W-1:0] all_out = {pcif_out, pci_out, lcd_n, lcd_p, src_n, src_p, cpu_n, cpu_p};

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  int edge_cnt [W];
  int snap [W];
  int short_cnt [W];
  realtime last_t [W];

  function automatic real half_of(input int g);
    if (g < I_SRCP) return CLK_PERIOD / 2.0;
    if (g < I_PCI)  return SRC_PERIOD / 2.0;
    return PCI_PERIOD / 2.0;
  endfunction

  // edge counter and phase-width monitor per output bit
  for (genvar g = 0; g < W; g++) begin : g_mon
    always @(all_out[g]) begin
      edge_cnt[g] = edge_cnt[g] + 1;
      if (mon_on && (($realtime - last_t[g]) < (half_of(g) - 0.5)))
        short_cnt[g] = short_cnt[g] + 1;
      last_t[g] = $realtime;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic window(input int len);
    for (int g = 0; g < W; g++) snap[g] = edge_cnt[g];
    #(len);
  endtask

  task automatic expect_run(input int g, input string tag);
    int moved = edge_cnt[g] - snap[g];
    check(moved > 0, tag, $sformatf("output %0d edges", g), moved, 1);
  endtask

  task automatic expect_park(input int g, input logic lvl, input string tag);
    int moved = edge_cnt[g] - snap[g];
    check(moved == 0, tag, $sformatf("output %0d edges", g), moved, 0);
    check(all_out[g] == lvl, tag, $sformatf("output %0d level", g), int'(all_out[g]), int'(lvl));
  endtask

  task automatic t_reset;
    window(2*PCI_PERIOD);
    for (int g = 0; g < W; g++) expect_run(g, "R11");
    for (int i = 0; i < NC; i++)
      check(cpu_p[i] != cpu_n[i], "R11", $sformatf("cpu pair %0d legs differ", i),
            int'(cpu_p[i] != cpu_n[i]), 1);
  endtask

  task automatic t_cpu_stop(input logic [NC-1:0] mask);
    cpu_stop_en = mask;
    cpu_stop_n = 1'b0;
    #(6*CLK_PERIOD);
    window(2*PCI_PERIOD);
    for (int i = 0; i < NC; i++) begin
      if (mask[i]) begin
        expect_park(I_CPUP+i, 1'b1, "R1");
        expect_park(I_CPUN+i, 1'b0, "R1");
      end else begin
        expect_run(I_CPUP+i, "R2");
        expect_run(I_CPUN+i, "R2");
        check(cpu_p[i] != cpu_n[i], "R2", "free pair legs differ", int'(cpu_p[i] != cpu_n[i]), 1);
      end
    end
    expect_run(I_SRCP, "R10");
    expect_run(I_LCDP, "R10");
    expect_run(I_PCI, "R10");
    expect_run(I_PCIF, "R10");
    cpu_stop_n = 1'b1;
    #(4*CLK_PERIOD);
    window(4*CLK_PERIOD);
    for (int i = 0; i < NC; i++) begin
      expect_run(I_CPUP+i, "R3");
      expect_run(I_CPUN+i, "R3");
    end
  endtask

  // use_sw selects the software bit instead of the pin
  task automatic t_pci_stop(input logic s_en, input logic l_en, input logic f_en,
                            input bit use_sw, input string tag);
    src_stop_en = s_en;
    lcd_stop_en = l_en;
    pcif_stop_en = f_en;
    if (use_sw) sw_run = 1'b0; else pci_stop_n = 1'b0;
    #(6*PCI_PERIOD);
    window(2*PCI_PERIOD);
    for (int i = 0; i < NP; i++) expect_park(I_PCI+i, 1'b0, tag);
    for (int i = 0; i < NS; i++) begin
      if (s_en) begin
        expect_park(I_SRCP+i, 1'b1, tag);
        expect_park(I_SRCN+i, 1'b0, tag);
      end else begin
        expect_run(I_SRCP+i, "R6");
        expect_run(I_SRCN+i, "R6");
      end
    end
    if (l_en) begin
      expect_park(I_LCDP, 1'b1, tag);
      expect_park(I_LCDN, 1'b0, tag);
    end else expect_run(I_LCDP, "R6");
    if (f_en) expect_park(I_PCIF, 1'b0, tag);
    else      expect_run(I_PCIF, "R6");
    for (int i = 0; i < NC; i++) expect_run(I_CPUP+i, "R10");
    if (use_sw) sw_run = 1'b1; else pci_stop_n = 1'b1;
    #(4*PCI_PERIOD);
    window(2*PCI_PERIOD);
    for (int g = I_SRCP; g < W; g++) expect_run(g, use_sw ? "R8" : "R7");
  endtask

  task automatic t_oe;
    mon_on = 1'b0;
    cpu_oe = 2'b10;
    src_oe[1] = 1'b0;
    lcd_oe = 1'b0;
    pci_oe[2] = 1'b0;
    pcif_oe = 1'b0;
    #(2*PCI_PERIOD);
    window(2*PCI_PERIOD);
    expect_park(I_CPUP, 1'b0, "R9");
    expect_park(I_CPUN, 1'b0, "R9");
    expect_park(I_SRCP+1, 1'b0, "R9");
    expect_park(I_SRCN+1, 1'b0, "R9");
    expect_park(I_LCDP, 1'b0, "R9");
    expect_park(I_LCDN, 1'b0, "R9");
    expect_park(I_PCI+2, 1'b0, "R9");
    expect_park(I_PCIF, 1'b0, "R9");
    expect_run(I_CPUP+1, "R9");
    expect_run(I_PCI, "R9");
    // disabled pair stays low under a stop, an enabled one parks high
    src_stop_en = 1'b1;
    pci_stop_n = 1'b0;
    #(6*PCI_PERIOD);
    window(2*PCI_PERIOD);
    expect_park(I_SRCP+1, 1'b0, "R9");
    expect_park(I_SRCN+1, 1'b0, "R9");
    expect_park(I_SRCP, 1'b1, "R9");
    pci_stop_n = 1'b1;
    cpu_oe = '1;
    src_oe = '1;
    lcd_oe = 1'b1;
    pci_oe = '1;
    pcif_oe = 1'b1;
    #(6*PCI_PERIOD);
    mon_on = 1'b1;
  endtask

  task automatic t_phases;
    int s_cpu = 0, s_src = 0, s_pci = 0;
    for (int g = 0; g < W; g++) begin
      if (g < I_SRCP)     s_cpu += short_cnt[g];
      else if (g < I_PCI) s_src += short_cnt[g];
      else                s_pci += short_cnt[g];
    end
    check(s_cpu == 0, "R4", "short phases on CPU outputs", s_cpu, 0);
    check(s_src == 0, "R4", "short phases on SRC/LCD outputs", s_src, 0);
    check(s_pci == 0, "R4", "short phases on PCI/PCIF outputs", s_pci, 0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    #(100000*CLK_PERIOD);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL all watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < W; g++) begin
      edge_cnt[g] = 0;
      snap[g] = 0;
      short_cnt[g] = 0;
      last_t[g] = 0.0;
    end
    rst_n = 1'b0;
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    sw_run = 1'b1;
    cpu_stop_en = '0;
    src_stop_en = 1'b0;
    lcd_stop_en = 1'b0;
    pcif_stop_en = 1'b0;
    cpu_oe = '1;
    src_oe = '1;
    lcd_oe = 1'b1;
    pci_oe = '1;
    pcif_oe = 1'b1;
    #3;
    #(5*CLK_PERIOD);
    rst_n = 1'b1;
    #(4*PCI_PERIOD);
    mon_on = 1'b1;

    t_reset();
    t_cpu_stop(2'b01);
    t_cpu_stop(2'b10);
    t_cpu_stop(2'b11);
    t_pci_stop(1'b1, 1'b0, 1'b1, 1'b0, "R5");
    t_pci_stop(1'b0, 1'b1, 1'b0, 1'b0, "R5");
    t_pci_stop(1'b1, 1'b1, 1'b1, 1'b1, "R8");
    t_oe();
    t_cpu_stop(2'b01);
    t_phases();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule